// File: doc/BRIEF.md
# Keyed Software Reset Controller

This block lets software hold other on-chip blocks in reset through a small register port. It has a bank of reset bits, one for each output line. A write to that bank is accepted only when the top byte of the written word carries a fixed key value, so a stray or corrupted store cannot reset a peripheral. There is also an optional grant mask. It holds one bit per line, and a line can only be driven by software while its grant bit is set. Each output is high when both its reset bit and its grant bit are set, and it is taken from a flop so that it cannot glitch.

The intended software sequence for putting a line into reset is to set its grant bit and then its reset bit. To release the line, software clears the reset bit and then the grant bit. The outputs are active high. Each consumer synchronises the line it receives into its own clock domain.

Top module: `srst_ctrl`

## Requirements
- R1: After reset, the reset-bit register, the grant register and every line output are zero, and both registers read back as zero.
- R2: A write to offset 0x18 whose bits 31:24 equal 0x88 loads bits NUM_LINES-1:0 of the write data into the reset-bit register at the write's clock edge.
- R3: A write to offset 0x18 whose bits 31:24 differ from 0x88 leaves the reset-bit register unchanged.
- R4: A read of offset 0x18 returns the reset bits in bits NUM_LINES-1:0 and zero in every higher bit, including the key field 31:24.
- R5: A write to offset 0xFC loads bits NUM_LINES-1:0 into the grant register whatever its top byte holds; a read of 0xFC returns the grant bits with all higher bits zero.
- R6: Line output n, registered, equals the AND of reset bit n and grant bit n, one clock after those bits change.
- R7: With HAS_ENABLE=0 the grant term is all ones, so each output follows its reset bit; a read of 0xFC returns zero and writes to it have no effect on any output.
- R8: A write to any offset other than 0x18 and 0xFC changes no register, and a read of such an offset returns zero.
- R9: Setting the grant bit alone leaves the line low; the following keyed write of the reset bit raises it. When the reset bit is cleared while the grant bit stays set, the line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe, one access per cycle |
| reg_wdata_i | input | DATA_W (32) | Write data; top KEY_W bits carry the key |
| reg_rdata_o | output | DATA_W (32) | Read data for reg_addr_i, combinational |
| line_rst_o | output | NUM_LINES (24) | Registered active-high reset lines |

## Verification
The bench builds two copies of the block on one shared register bus. One copy uses the defaults: 24 lines with the grant mask present. This exercises key acceptance and rejection, masking of the write data above the line count, and gating of each output by its grant bit, including the release order. The second copy has 5 lines and HAS_ENABLE=0. This brings the constant-grant variant within reach: its outputs follow the reset bits directly, and its grant offset reads zero even after writes. The narrow width also shows that bits above the line count read back as zero.

// File: rtl/srst_pkg.sv
package srst_pkg;

   // Which register a bus address selects.
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_SYS  = 2'd1,
      SEL_EN   = 2'd2
   } srst_sel_e;

   // Decoded write command for one cycle.
   typedef struct packed {
      logic sys_ld;   // keyed write to reset-bit register accepted
      logic en_ld;    // write to grant register
      logic key_bad;  // write to reset-bit register rejected
   } srst_wcmd_s;

endpackage

// File: rtl/srst_wr_decode.sv
module srst_wr_decode
   import srst_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 8,
   parameter int unsigned          KEY_W      = 8,
   parameter logic [KEY_W-1:0]     KEY_VAL    = 8'h88,
   parameter logic [ADDR_W-1:0]    SYS_OFFSET = 8'h18,
   parameter logic [ADDR_W-1:0]    EN_OFFSET  = 8'hFC,
   parameter bit                   HAS_ENABLE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [KEY_W-1:0]  key_i,
   output srst_sel_e         sel_o,
   output srst_wcmd_s        cmd_o
);

   logic key_match;

   always_comb begin
      if (addr_i == SYS_OFFSET)
         sel_o = SEL_SYS;
      else if (HAS_ENABLE && (addr_i == EN_OFFSET))
         sel_o = SEL_EN;
      else
         sel_o = SEL_NONE;
   end

   assign key_match = (key_i == KEY_VAL);

   always_comb begin
      cmd_o         = '0;
      cmd_o.sys_ld  = wr_i && (sel_o == SEL_SYS) && key_match;
      cmd_o.key_bad = wr_i && (sel_o == SEL_SYS) && !key_match;
      cmd_o.en_ld   = wr_i && (sel_o == SEL_EN);
   end

endmodule

// File: rtl/srst_reg_bank.sv
module srst_reg_bank #(
   parameter int unsigned WIDTH = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end

endmodule

// File: rtl/srst_out_stage.sv
module srst_out_stage #(
   parameter int unsigned NUM_LINES = 24
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_LINES-1:0] sys_q_i,
   input  logic [NUM_LINES-1:0] en_q_i,
   output logic [NUM_LINES-1:0] line_o
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            line_o[i] <= 1'b0;
         else
            line_o[i] <= sys_q_i[i] & en_q_i[i];
      end
   end

endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
   import srst_pkg::*;
#(
   parameter int unsigned          NUM_LINES  = 24,
   parameter int unsigned          ADDR_W     = 8,
   parameter int unsigned          DATA_W     = 32,
   parameter int unsigned          KEY_W      = 8,
   parameter logic [KEY_W-1:0]     KEY_VAL    = 8'h88,
   parameter logic [ADDR_W-1:0]    SYS_OFFSET = 8'h18,
   parameter logic [ADDR_W-1:0]    EN_OFFSET  = 8'hFC,
   parameter bit                   HAS_ENABLE = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic                 reg_wr_i,
   input  logic [DATA_W-1:0]    reg_wdata_i,
   output logic [DATA_W-1:0]    reg_rdata_o,
   output logic [NUM_LINES-1:0] line_rst_o
);

   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   // Elaboration-time parameter checks
   if (KEY_W == 0 || KEY_W >= DATA_W) begin : g_bad_key
      $error("srst_ctrl: KEY_W must be between 1 and DATA_W-1");
   end
   if (NUM_LINES == 0 || NUM_LINES > KEY_LSB) begin : g_bad_lines
      $error("srst_ctrl: NUM_LINES must fit below the key field");
   end
   if (SYS_OFFSET == EN_OFFSET) begin : g_bad_map
      $error("srst_ctrl: register offsets must differ");
   end
   if (SYS_OFFSET[1:0] != 2'b00 || EN_OFFSET[1:0] != 2'b00) begin : g_bad_align
      $error("srst_ctrl: register offsets must be word aligned");
   end

   srst_sel_e            sel;
   srst_wcmd_s           cmd;
   logic [NUM_LINES-1:0] sys_q;
   logic [NUM_LINES-1:0] en_q;

   srst_wr_decode #(
      .ADDR_W     (ADDR_W),
      .KEY_W      (KEY_W),
      .KEY_VAL    (KEY_VAL),
      .SYS_OFFSET (SYS_OFFSET),
      .EN_OFFSET  (EN_OFFSET),
      .HAS_ENABLE (HAS_ENABLE)
   ) i_decode (
      .addr_i (reg_addr_i),
      .wr_i   (reg_wr_i),
      .key_i  (reg_wdata_i[DATA_W-1 -: KEY_W]),
      .sel_o  (sel),
      .cmd_o  (cmd)
   );

   srst_reg_bank #(.WIDTH(NUM_LINES)) i_sys_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cmd.sys_ld),
      .d_i    (reg_wdata_i[NUM_LINES-1:0]),
      .q_o    (sys_q)
   );

   if (HAS_ENABLE) begin : g_en
      srst_reg_bank #(.WIDTH(NUM_LINES)) i_en_bank (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (cmd.en_ld),
         .d_i    (reg_wdata_i[NUM_LINES-1:0]),
         .q_o    (en_q)
      );
   end else begin : g_no_en
      logic unused_en_ld;
      assign unused_en_ld = cmd.en_ld;
      assign en_q = '1;
   end

   // Data bits between the line field and the key field carry nothing.
   if (NUM_LINES < KEY_LSB) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^reg_wdata_i[KEY_LSB-1:NUM_LINES];
   end

   logic unused_reject;
   assign unused_reject = cmd.key_bad;

   always_comb begin
      reg_rdata_o = '0;
      unique case (sel)
         SEL_SYS: reg_rdata_o = DATA_W'(sys_q);
         SEL_EN:  reg_rdata_o = DATA_W'(en_q);
         default: reg_rdata_o = '0;
      endcase
   end

   srst_out_stage #(.NUM_LINES(NUM_LINES)) i_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sys_q_i (sys_q),
      .en_q_i  (en_q),
      .line_o  (line_rst_o)
   );

endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk #(
   parameter int unsigned          NUM_LINES  = 24,
   parameter int unsigned          ADDR_W     = 8,
   parameter int unsigned          DATA_W     = 32,
   parameter int unsigned          KEY_W      = 8,
   parameter logic [KEY_W-1:0]     KEY_VAL    = 8'h88,
   parameter logic [ADDR_W-1:0]    SYS_OFFSET = 8'h18,
   parameter logic [ADDR_W-1:0]    EN_OFFSET  = 8'hFC,
   parameter bit                   HAS_ENABLE = 1'b1
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [ADDR_W-1:0]    reg_addr_i,
   input logic                 reg_wr_i,
   input logic [DATA_W-1:0]    reg_wdata_i,
   input logic [DATA_W-1:0]    reg_rdata_o,
   input logic [NUM_LINES-1:0] line_rst_o,
   input logic [NUM_LINES-1:0] sys_q,
   input logic [NUM_LINES-1:0] en_q
);

   logic key_ok;
   logic hit_sys;
   logic hit_en;
   assign key_ok  = (reg_wdata_i[DATA_W-1 -: KEY_W] == KEY_VAL);
   assign hit_sys = (reg_addr_i == SYS_OFFSET);
   assign hit_en  = (reg_addr_i == EN_OFFSET);

   assert_keyed_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && hit_sys && key_ok) |=> (sys_q == $past(reg_wdata_i[NUM_LINES-1:0])));

   assert_bad_key_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && hit_sys && !key_ok) |=> $stable(sys_q));

   assert_key_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_sys |-> (reg_rdata_o[DATA_W-1:NUM_LINES] == '0));

   assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (line_rst_o == $past(sys_q & en_q)));

   assert_stray_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && !hit_sys && !hit_en) |=> ($stable(sys_q) && $stable(en_q)));

   assert_stray_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit_sys && !hit_en) |-> (reg_rdata_o == '0));

   if (HAS_ENABLE) begin : g_en_chk
      assert_en_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (reg_wr_i && hit_en) |=> (en_q == $past(reg_wdata_i[NUM_LINES-1:0])));
   end else begin : g_open_chk
      assert_open_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         hit_en |-> (reg_rdata_o == '0));
   end

endmodule

bind srst_ctrl srst_ctrl_chk #(
   .NUM_LINES  (NUM_LINES),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .KEY_W      (KEY_W),
   .KEY_VAL    (KEY_VAL),
   .SYS_OFFSET (SYS_OFFSET),
   .EN_OFFSET  (EN_OFFSET),
   .HAS_ENABLE (HAS_ENABLE)
) i_srst_ctrl_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reg_addr_i  (reg_addr_i),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .line_rst_o  (line_rst_o),
   .sys_q       (sys_q),
   .en_q        (en_q)
);

// File: tb/test_srst_ctrl.sv
module test_srst_ctrl;

   localparam logic [7:0] A_SYS = 8'h18;
   localparam logic [7:0] A_EN  = 8'hFC;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata2;
   logic [23:0] lines;
   logic [4:0]  lines2;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   srst_ctrl i_srst_ctrl (
      .clk_i (clk), .rst_ni (rst_ni), .reg_addr_i (addr), .reg_wr_i (wr),
      .reg_wdata_i (wdata), .reg_rdata_o (rdata), .line_rst_o (lines)
   );

   srst_ctrl #(.NUM_LINES(5), .HAS_ENABLE(1'b0)) i_srst_ctrl_open (
      .clk_i (clk), .rst_ni (rst_ni), .reg_addr_i (addr), .reg_wr_i (wr),
      .reg_wdata_i (wdata), .reg_rdata_o (rdata2), .line_rst_o (lines2)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d2);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata; d2 = rdata2;
   endtask

   // outputs follow a register change one edge later
   task automatic settle;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d, d2;
      bus_rd(A_SYS, d, d2);
      check("R1 sys reads zero", d, 32'h0);
      bus_rd(A_EN, d, d2);
      check("R1 grant reads zero", d, 32'h0);
      check("R1 lines low", {8'h0, lines}, 32'h0);
   endtask

   task automatic t_keyed;
      logic [31:0] d, d2;
      bus_wr(A_EN, 32'h00FF_FFFF);
      bus_wr(A_SYS, 32'h88A5_A5A5);
      bus_rd(A_SYS, d, d2);
      check("R2 keyed write loads", d, 32'h00A5_A5A5);
      check("R4 key field reads zero", {24'h0, d[31:24]}, 32'h0);
      check("R6 lines follow bits", {8'h0, lines}, 32'h00A5_A5A5);
   endtask

   task automatic t_bad_key;
      logic [31:0] d, d2;
      bus_wr(A_SYS, 32'h7700_0F0F);
      bus_rd(A_SYS, d, d2);
      check("R3 key 0x77 rejected", d, 32'h00A5_A5A5);
      bus_wr(A_SYS, 32'h0000_0000);
      bus_rd(A_SYS, d, d2);
      check("R3 key 0x00 rejected", d, 32'h00A5_A5A5);
      bus_wr(A_SYS, 32'h8900_0001);
      bus_rd(A_SYS, d, d2);
      check("R3 key 0x89 rejected", d, 32'h00A5_A5A5);
      check("R3 lines unchanged", {8'h0, lines}, 32'h00A5_A5A5);
   endtask

   task automatic t_grant;
      logic [31:0] d, d2;
      bus_wr(A_EN, 32'hFFFF_FFFF);
      bus_rd(A_EN, d, d2);
      check("R5 grant upper bits zero", d, 32'h00FF_FFFF);
      bus_wr(A_EN, 32'h1200_0003);
      bus_rd(A_EN, d, d2);
      check("R5 grant write without key", d, 32'h0000_0003);
      bus_wr(A_SYS, 32'h88FF_FFFF);
      settle();
      check("R6 grant masks lines", {8'h0, lines}, 32'h0000_0003);
   endtask

   task automatic t_stray;
      logic [31:0] d, d2;
      bus_wr(8'h14, 32'h8800_0000);
      bus_wr(8'h00, 32'h8800_0000);
      bus_rd(A_SYS, d, d2);
      check("R8 sys untouched by stray write", d, 32'h00FF_FFFF);
      bus_rd(A_EN, d, d2);
      check("R8 grant untouched by stray write", d, 32'h0000_0003);
      bus_rd(8'h14, d, d2);
      check("R8 stray read zero", d, 32'h0);
   endtask

   task automatic t_sequence;
      logic [31:0] d, d2;
      bus_wr(A_SYS, 32'h8800_0000);
      bus_wr(A_EN, 32'h0000_0000);
      settle();
      check("R9 cleared", {8'h0, lines}, 32'h0);
      bus_wr(A_EN, 32'h0000_0020);
      settle();
      check("R9 grant alone keeps line low", {8'h0, lines}, 32'h0);
      bus_wr(A_SYS, 32'h8800_0020);
      check("R9 one edge after load still low", {8'h0, lines}, 32'h0);
      settle();
      check("R9 line raised", {8'h0, lines}, 32'h0000_0020);
      bus_wr(A_SYS, 32'h8800_0000);
      settle();
      check("R9 line drops with grant kept", {8'h0, lines}, 32'h0);
      bus_rd(A_EN, d, d2);
      check("R9 grant still set", d, 32'h0000_0020);
      bus_wr(A_EN, 32'h0000_0000);
   endtask

   task automatic t_open;
      logic [31:0] d, d2;
      bus_wr(A_SYS, 32'h8800_0016);
      settle();
      check("R7 open variant follows bits", {27'h0, lines2}, 32'h0000_0016);
      bus_wr(A_EN, 32'h0000_0000);
      settle();
      check("R7 grant write no effect", {27'h0, lines2}, 32'h0000_0016);
      bus_rd(A_EN, d, d2);
      check("R7 grant reads zero", d2, 32'h0);
      bus_wr(A_SYS, 32'h88FF_FFFF);
      bus_rd(A_SYS, d, d2);
      check("R4 narrow upper bits zero", d2, 32'h0000_001F);
      bus_wr(A_SYS, 32'h4400_0000);
      bus_rd(A_SYS, d, d2);
      check("R3 open variant rejects bad key", d2, 32'h0000_001F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      t_reset();
      t_keyed();
      t_bad_key();
      t_grant();
      t_stray();
      t_sequence();
      t_open();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule